// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is the controller for a door lock. A user enters three digits, one after the other. Each digit is a 4-bit value, and a one-cycle entry strobe marks it as valid. The door output goes high only when all three entries match the stored combination, in the stored order. The three stored digits are parameters. By default the combination is 3, then 4, then 2.

Inside, the block has three parts: a selector that chooses which stored digit applies to the current stage, an equality comparator, and a state register. The state register uses five codes:

| State | Code |
|---|---|
| Error | `0000` |
| Stage 1 | `0001` |
| Stage 2 | `0010` |
| Stage 3 | `0100` |
| Open | `1000` |

The low three bits of the state act directly as the one-hot select for the digit selector. The top bit is the door output. A single wrong digit sends the lock to the error state. Only reset leaves the error state, and only reset leaves the open state. Idle cycles between digits are allowed.

Top module: `combo_lock`

## Requirements
- R1: A synchronous, active-high reset puts the lock at stage 1 with the door closed (`door_open`=0), whatever the strobe and digit inputs are. This holds from any state, including open and error.
- R2: In stages 1 to 3, a clock edge with `digit_strobe` low leaves the state unchanged. The value on `digit_in` has no effect in that cycle.
- R3: In a stage, a strobed digit equal to that stage's stored digit advances the lock by one step: stage 1 to stage 2, stage 2 to stage 3, stage 3 to open.
- R4: In a stage, a strobed digit that differs from that stage's stored digit moves the lock to the error state.
- R5: The open state holds on every clock edge until reset, whatever digits are strobed.
- R6: The error state holds, with the door closed, on every clock edge until reset. Entering the correct combination afterwards does not open the door.
- R7: Stage 1 compares against `CODE_SEQ[3:0]`, stage 2 against `CODE_SEQ[7:4]` and stage 3 against `CODE_SEQ[11:8]`. A permutation of the correct digits therefore fails.
- R8: Each clock cycle in which `digit_strobe` is high counts as one digit entry. Holding the strobe high for several cycles enters several digits.
- R9: `door_open` is 1 only in the open state. It first goes high on the clock edge that samples the third correct strobed digit, and it is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| digit_strobe | input | 1 | High for each cycle that carries one entered digit |
| digit_in | input | DIGIT_W (4) | Entered digit value |
| door_open | output | 1 | 1 = door open, 0 = closed |

## Verification
The bench attacks the following corner cases. A wrong digit at each of the three positions must each end in a locked-out lock, and the correct digits entered later must not open it. A design that compared only the final digit, or that dropped back to stage 1 on an error, would open here. A permutation of the right digits exposes a selector that indexes the stored digits in the wrong order. Idle gaps with junk on the digit bus catch a design that samples digits without the strobe. A strobe held high for several cycles checks that each cycle counts as a separate entry. Reset is applied from both the open and the error state and must leave the lock ready to accept the full combination again.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

    localparam int STAGES  = 3;
    localparam int STATE_W = STAGES + 1;

    typedef enum logic [STATE_W-1:0] {
        ST_ERR  = 4'b0000,
        ST_DIG1 = 4'b0001,
        ST_DIG2 = 4'b0010,
        ST_DIG3 = 4'b0100,
        ST_OPEN = 4'b1000
    } lock_state_t;

    typedef struct packed {
        lock_state_t state;
    } lock_regs_t;

endpackage

// File: rtl/digit_select.sv
module digit_select
    import combo_lock_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter logic [STAGES*DIGIT_W-1:0] CODE_SEQ = {4'd2, 4'd4, 4'd3}
) (
    input  logic [STAGES-1:0]  sel,
    output logic [DIGIT_W-1:0] ref_digit
);

    logic [DIGIT_W-1:0] term [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_term
        assign term[i] = {DIGIT_W{sel[i]}} & CODE_SEQ[i*DIGIT_W +: DIGIT_W];
    end

    always_comb begin
        ref_digit = '0;
        for (int i = 0; i < STAGES; i++) begin
            ref_digit = ref_digit | term[i];
        end
    end

endmodule

// File: rtl/digit_match.sv
module digit_match #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] entered,
    input  logic [DIGIT_W-1:0] expected,
    output logic               match
);

    assign match = (entered == expected);

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import combo_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              match,
    output logic [STAGES-1:0] sel,
    output logic              door_open
);

    lock_regs_t regs_d, regs_q;
    logic       in_stage;

    assign in_stage = (regs_q.state == ST_DIG1) || (regs_q.state == ST_DIG2) ||
                      (regs_q.state == ST_DIG3);

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = ST_DIG1;
        end else begin
            unique case (regs_q.state)
                ST_DIG1, ST_DIG2, ST_DIG3: begin
                    if (strobe) begin
                        regs_d.state = match ? lock_state_t'(regs_q.state << 1) : ST_ERR;
                    end
                end
                ST_OPEN: regs_d.state = ST_OPEN;
                default: regs_d.state = ST_ERR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign sel       = regs_q.state[STAGES-1:0];
    assign door_open = regs_q.state[STAGES];

    a_r1_reset_to_first: assert property (@(posedge clk)
        rst |=> (regs_q.state == ST_DIG1) && !door_open);

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (in_stage && !strobe) |=> $stable(regs_q.state));

    a_r3_advance_on_match: assert property (@(posedge clk) disable iff (rst)
        (in_stage && strobe && match) |=> regs_q.state == lock_state_t'($past(regs_q.state) << 1));

    a_r4_error_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        (in_stage && strobe && !match) |=> regs_q.state == ST_ERR);

    a_r5_open_sticky: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_OPEN) |=> door_open);

    a_r6_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_ERR) |=> (regs_q.state == ST_ERR) && !door_open);

    a_r9_state_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(regs_q.state));

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter logic [STAGES*DIGIT_W-1:0] CODE_SEQ = {4'd2, 4'd4, 4'd3}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               digit_strobe,
    input  logic [DIGIT_W-1:0] digit_in,
    output logic               door_open
);

    logic [STAGES-1:0]  sel;
    logic [DIGIT_W-1:0] ref_digit;
    logic               match;

    digit_select #(.DIGIT_W(DIGIT_W), .CODE_SEQ(CODE_SEQ)) u_select (
        .sel       (sel),
        .ref_digit (ref_digit)
    );

    digit_match #(.DIGIT_W(DIGIT_W)) u_match (
        .entered  (digit_in),
        .expected (ref_digit),
        .match    (match)
    );

    lock_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (digit_strobe),
        .match     (match),
        .sel       (sel),
        .door_open (door_open)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_r7_chk
        a_r7_stage_digit: assert property (@(posedge clk) disable iff (rst)
            (sel == STAGES'(1 << i)) |-> (ref_digit == CODE_SEQ[i*DIGIT_W +: DIGIT_W]));
    end

endmodule

// File: tb/sim_combo_lock.sv
module sim_combo_lock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       digit_strobe = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic       door_open;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    combo_lock u0 (
        .clk          (clk),
        .rst          (rst),
        .digit_strobe (digit_strobe),
        .digit_in     (digit_in),
        .door_open    (door_open)
    );

    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (door_open !== exp) begin
            n_fail++;
            $display("FAIL %s: door_open=%b expected=%b", tag, door_open, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic enter(input logic [3:0] d);
        digit_strobe = 1'b1;
        digit_in = d;
        @(negedge clk);
        digit_strobe = 1'b0;
        digit_in = 4'hF;
    endtask

    task automatic idle(input int n, input logic [3:0] junk);
        for (int i = 0; i < n; i++) begin
            digit_in = junk + 4'(i);
            @(negedge clk);
        end
    endtask

    task automatic enter_code();
        enter(4'd3); enter(4'd4); enter(4'd2);
    endtask

    task automatic t_reset_state();
        rst = 1'b1; digit_strobe = 1'b1; digit_in = 4'd3;
        @(negedge clk); @(negedge clk);
        check(1'b0, "R1 reset closed");
        digit_strobe = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_correct();
        do_reset();
        enter(4'd3); check(1'b0, "R3 after digit 1");
        enter(4'd4); check(1'b0, "R3 after digit 2");
        enter(4'd2); check(1'b1, "R9 opens on third");
        idle(5, 4'd0); check(1'b1, "R5 stays open idle");
        enter(4'd7); enter(4'd3); check(1'b1, "R5 open ignores digits");
        do_reset(); check(1'b0, "R1 reset from open");
        enter_code(); check(1'b1, "R1 code accepted after reset");
    endtask

    task automatic t_wrong_first();
        do_reset();
        enter(4'd5); enter_code(); check(1'b0, "R4 wrong first digit");
        idle(3, 4'd3); check(1'b0, "R6 error holds");
        do_reset(); enter_code(); check(1'b1, "R1 reset from error");
    endtask

    task automatic t_wrong_second();
        do_reset();
        enter(4'd3); enter(4'd7); enter(4'd4); enter(4'd2);
        check(1'b0, "R4 wrong second digit");
        enter_code(); check(1'b0, "R6 error ignores code");
    endtask

    task automatic t_wrong_third();
        do_reset();
        enter(4'd3); enter(4'd4); enter(4'd9); check(1'b0, "R4 wrong third digit");
        enter(4'd2); check(1'b0, "R6 error after third");
    endtask

    task automatic t_idle_gaps();
        do_reset();
        idle(2, 4'd1);
        enter(4'd3); idle(4, 4'd8);
        enter(4'd4); idle(3, 4'd5);
        check(1'b0, "R2 idle holds stage");
        enter(4'd2); check(1'b1, "R2 opens with gaps");
    endtask

    task automatic t_order();
        do_reset();
        enter(4'd4); enter(4'd3); enter(4'd2); check(1'b0, "R7 swapped order");
        do_reset();
        enter(4'd2); enter(4'd4); enter(4'd3); check(1'b0, "R7 reversed order");
    endtask

    task automatic t_held_strobe();
        do_reset();
        digit_strobe = 1'b1; digit_in = 4'd3;
        @(negedge clk); @(negedge clk); @(negedge clk);
        digit_strobe = 1'b0;
        enter(4'd4); enter(4'd2); check(1'b0, "R8 held strobe repeats entry");
        do_reset();
        digit_strobe = 1'b1;
        digit_in = 4'd3; @(negedge clk);
        digit_in = 4'd4; @(negedge clk);
        digit_in = 4'd2; @(negedge clk);
        digit_strobe = 1'b0;
        check(1'b1, "R8 back-to-back entries");
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_correct();
        t_wrong_first();
        t_wrong_second();
        t_wrong_third();
        t_idle_gaps();
        t_order();
        t_held_strobe();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule